// File: doc/BRIEF.md
# Four-Stage In-Order Pipeline with Variable-Latency Execute

This block is the token-moving skeleton of an in-order pipeline with four stages: fetch, decode, execute and write. Each instruction enters through a valid/ready input as a token made of a tag, a two-bit execute latency and a data payload. Three registered slots carry the token forward: one between fetch and decode, one between decode and execute, and one between execute and write. The write stage shows the token on the output for one cycle.

An operation that needs more than one execute cycle keeps the execute slot for that many cycles. During each extra cycle the block raises a stall flag, holds both earlier slots, drops input ready, and sends an empty cycle into the write stage. Every later instruction is therefore delayed by exactly the extra cycles. Only one instruction is ever in execute. Results leave in the order their instructions arrived, and the result is the payload passed through unchanged.

Top module: `pipe4_top`

## Requirements
- R1: While the synchronous active-high reset is applied, and in the first cycle after it, `out_valid` and `stall` are low and `in_ready` is high.
- R2: A one-cycle instruction accepted at clock edge k (in_valid and in_ready both high at that edge) appears on the write outputs right after edge k+2. One-cycle instructions offered back to back complete one per cycle.
- R3: The execute latency is the 2-bit field `in_lat`, read as an unsigned number of cycles from 1 to 3. The code 0 gives one cycle, the same as code 1.
- R4: While an instruction of latency L is in execute, `stall` is high for its first L-1 cycles and low in its last cycle.
- R5: `out_valid` is low in every cycle that follows a stalled cycle. An instruction of latency L therefore puts L-1 empty cycles into the write stage.
- R6: `in_ready` is low exactly when `stall` is high. During a stall the decode-to-execute slot and the fetch-to-decode slot keep their contents, so the next instruction enters execute in the cycle after the current one finishes.
- R7: Valid write outputs show the tags and payloads of accepted instructions in acceptance order, with `out_data` equal to the accepted `in_data`.
- R8: An input held valid while `in_ready` is low is taken exactly once, at the first edge where `in_ready` is high.
- R9: Cycles with `in_valid` low insert no instruction. Only accepted instructions ever produce a cycle with `out_valid` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction token is offered |
| in_ready | output | 1 | The token is taken at the next edge |
| in_tag | input | TAG_W | Instruction tag |
| in_lat | input | LAT_W | Execute latency code (0 and 1 mean one cycle) |
| in_data | input | DATA_W | Operand payload |
| out_valid | output | 1 | The write stage holds a result this cycle |
| out_tag | output | TAG_W | Tag of the completing instruction |
| out_data | output | DATA_W | Result, which is the payload passed through |
| stall | output | 1 | Execute is busy with an extra cycle |

## Verification
The properties assume that the reset is held for at least one edge before operation and that `in_lat` only takes its 2-bit codes. Under these assumptions no operation can keep `stall` high for more than two cycles in a row. The stimulus also follows the handshake as a real producer would: once it offers a token, it holds `in_valid` and the token fields steady until an edge with `in_ready` high. This is what gives the hold and ordering properties their meaning. The sequences cover the latency codes 0 to 3 back to back, in idle gaps and in a pseudo-random mix, so that stalls start with and without a token already waiting in the earlier slots.

// File: rtl/pipe4_pkg.sv
package pipe4_pkg;

    parameter int TAG_W  = 8;
    parameter int LAT_W  = 2;
    parameter int DATA_W = 16;

    // One instruction token as it travels between stages
    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [LAT_W-1:0]  lat;
        logic [DATA_W-1:0] data;
    } slot_t;

    localparam slot_t EMPTY_SLOT = '0;

    // Cycles spent in execute: code 0 is read as one cycle
    function automatic logic [LAT_W-1:0] exec_cycles(input logic [LAT_W-1:0] code);
        return (code == '0) ? LAT_W'(1) : code;
    endfunction

endpackage

// File: rtl/pipe4_slot.sv
module pipe4_slot
    import pipe4_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  slot_t d,
    output slot_t q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= EMPTY_SLOT;
        else if (load)
            q <= d;
    end

endmodule

// File: rtl/pipe4_exec.sv
module pipe4_exec
    import pipe4_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  slot_t cur,      // token held in execute
    input  slot_t nxt,      // token waiting in decode
    output logic  hold,
    output logic  finish
);

    logic [LAT_W-1:0] left_q;

    assign hold   = cur.vld && (left_q > LAT_W'(1));
    assign finish = cur.vld && !hold;

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (!hold)
            left_q <= nxt.vld ? exec_cycles(nxt.lat) : '0;
        else
            left_q <= left_q - LAT_W'(1);
    end

endmodule

// File: rtl/pipe4_top.sv
module pipe4_top
    import pipe4_pkg::*;
#(
    parameter int N_FRONT = 2       // slots frozen by a stall
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [LAT_W-1:0]  in_lat,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [TAG_W-1:0]  out_tag,
    output logic [DATA_W-1:0] out_data,
    output logic              stall
);

    slot_t chain [0:N_FRONT];
    slot_t exe_slot;
    slot_t wb_d;
    slot_t wb_q;
    logic  busy;
    logic  done;

    always_comb begin
        chain[0].vld  = in_valid;
        chain[0].tag  = in_tag;
        chain[0].lat  = in_lat;
        chain[0].data = in_data;
    end

    for (genvar i = 0; i < N_FRONT; i++) begin : g_front
        pipe4_slot u_slot (
            .clk  (clk),
            .rst  (rst),
            .load (!busy),
            .d    (chain[i]),
            .q    (chain[i+1])
        );
    end

    assign exe_slot = chain[N_FRONT];

    pipe4_exec u_exec (
        .clk    (clk),
        .rst    (rst),
        .cur    (exe_slot),
        .nxt    (chain[N_FRONT-1]),
        .hold   (busy),
        .finish (done)
    );

    assign wb_d = done ? exe_slot : EMPTY_SLOT;

    pipe4_slot u_wb (
        .clk  (clk),
        .rst  (rst),
        .load (1'b1),
        .d    (wb_d),
        .q    (wb_q)
    );

    assign in_ready  = !busy;
    assign stall     = busy;
    assign out_valid = wb_q.vld;
    assign out_tag   = wb_q.tag;
    assign out_data  = wb_q.data;

endmodule

// File: rtl/pipe4_chk.sv
module pipe4_chk
    import pipe4_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  stall,
    input logic  out_valid,
    input slot_t exe_slot
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && !stall));

    // R5
    bubble_after_stall_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> !out_valid);

    // R6
    exec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(exe_slot));

    // R3
    max_stall_run_chk: assert property (@(posedge clk) disable iff (rst)
        (stall && $past(stall)) |=> !stall);

endmodule

bind pipe4_top pipe4_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .stall     (stall),
    .out_valid (out_valid),
    .exe_slot  (exe_slot)
);

// File: tb/test_pipe4_top.sv
module test_pipe4_top;
    import pipe4_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [TAG_W-1:0]  in_tag = '0;
    logic [LAT_W-1:0]  in_lat = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic [TAG_W-1:0]  out_tag;
    logic [DATA_W-1:0] out_data;
    logic              stall;

    always #2 clk = ~clk;

    pipe4_top i_pipe4_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_tag(in_tag), .in_lat(in_lat), .in_data(in_data),
        .out_valid(out_valid), .out_tag(out_tag), .out_data(out_data),
        .stall(stall)
    );

    int edge_n = 0;
    int checks = 0;
    int errors = 0;
    int next_free = 0;
    bit done_flag = 0;
    int q_tag[$], q_data[$], q_out[$], q_s[$], q_L[$];

    always @(posedge clk) edge_n++;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", what, act, exp, edge_n);
        end
    endtask

    // Offer one token; hold it until accepted (R8)
    task automatic send(input int tag, input int lat, input int data);
        int a, L, s;
        @(negedge clk);
        in_valid = 1'b1;
        in_tag   = TAG_W'(tag);
        in_lat   = LAT_W'(lat);
        in_data  = DATA_W'(data);
        while (!in_ready) @(negedge clk);
        a = edge_n + 1;
        L = (lat == 0) ? 1 : lat;     // R3 code 0 means one cycle
        s = (a + 1 > next_free) ? a + 1 : next_free;
        next_free = s + L;
        q_tag.push_back(tag);
        q_data.push_back(data);
        q_s.push_back(s);
        q_L.push_back(L);
        q_out.push_back(s + L);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 1; i < n; i++) @(negedge clk);
    endtask

    // Reference comparison on every cycle
    always @(negedge clk) begin
        if (!rst && !done_flag) begin
            bit exp_v;
            bit exp_st;
            exp_v  = (q_out.size() > 0) && (q_out[0] == edge_n);
            exp_st = 1'b0;
            for (int i = 0; i < q_s.size(); i++)
                if (q_s[i] <= edge_n && edge_n < q_s[i] + q_L[i] - 1) exp_st = 1'b1;
            chk(out_valid == exp_v, "R2 R5 R9 out_valid", int'(out_valid), int'(exp_v));
            chk(stall == exp_st, "R3 R4 stall", int'(stall), int'(exp_st));
            chk(in_ready == !exp_st, "R6 in_ready", int'(in_ready), int'(!exp_st));
            if (exp_v) begin
                chk(int'(out_tag) == q_tag[0], "R7 out_tag", int'(out_tag), q_tag[0]);
                chk(int'(out_data) == q_data[0], "R7 out_data", int'(out_data), q_data[0]);
                void'(q_tag.pop_front());
                void'(q_data.pop_front());
                void'(q_out.pop_front());
                void'(q_s.pop_front());
                void'(q_L.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        chk(stall == 1'b0, "R1 stall in reset", int'(stall), 0);
        chk(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
        rst = 1'b0;

        // R2 back-to-back one-cycle stream
        for (int i = 0; i < 8; i++) send(i, 1, 16'h1000 + i);
        idle(4);

        // R3 R4 R5 three-cycle op followed by waiting one-cycle ops
        send(20, 3, 16'hA003);
        send(21, 1, 16'hA011);
        send(22, 1, 16'hA012);
        send(23, 3, 16'hA013);
        send(24, 3, 16'hA014);
        idle(6);

        // R3 code 0 and code 2 mixed
        send(30, 0, 16'hB000);
        send(31, 2, 16'hB002);
        send(32, 0, 16'hB100);
        send(33, 2, 16'hB102);
        send(34, 1, 16'hB201);
        idle(5);

        // R9 gaps between tokens
        send(40, 2, 16'hC000);
        idle(3);
        send(41, 3, 16'hC001);
        idle(1);
        send(42, 1, 16'hC002);
        idle(2);
        send(43, 0, 16'hC003);
        idle(6);

        // R6 R7 R8 pseudo-random mix
        for (int i = 0; i < 200; i++) begin
            int r;
            r = $urandom % 8;
            if (r == 7) idle(1 + ($urandom % 3));
            send(100 + (i % 150), $urandom % 4, $urandom % 65536);
        end
        idle(12);

        // R8 every accepted token has left exactly once
        chk(q_out.size() == 0, "R8 tokens left in flight", q_out.size(), 0);
        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule